// File: doc/BRIEF.md
# Received Word Byte-Serial Read Port

This block holds the most recent 32-bit word delivered by a serial receiver and lets a host read it one byte at a time over an 8-bit data bus. The receiver presents a one-cycle word-valid pulse together with the word and its bit-count error status. The port stores the word, raises a data-ready flag, and records the error status in an error flag. The host then pulses an active-low read strobe four times to collect the word, lowest byte first. While the strobe is low the port drives the current byte and enables the pad driver. While the strobe is high the driver enable is low, so a tri-state pad buffer outside the block releases the bus.

The read strobe is asynchronous to the system clock. It is synchronised, and its trailing (rising) edge moves a byte pointer forward. The pointer stops at the last byte until the next word arrives. Data-ready falls on the trailing edge of the first read after a word arrives. A newly arriving word always replaces the stored word, whether or not it has been read, and it sends the pointer back to the first byte. A host that is part way through a word therefore continues with the first byte of the new word. When a word arrives in the same cycle as a strobe edge, the word takes priority.

Top module: `rx_word_byte_port`

## Requirements
- R1: While reset is low, and after it is released, data-ready and the error flag are 0, the stored word is all zeros and the pointer selects byte 0.
- R2: A word-valid pulse stores the word and sets data-ready to 1 from the next cycle.
- R3: Data-ready falls to 0 when the trailing edge of the first read strobe after a word has been registered. It stays 0 during later reads until another word arrives.
- R4: The driver enable is high exactly while the read strobe is low. During that time the data output carries the byte the pointer selects.
- R5: Byte k (k = 0..3) of a read sequence is bits [8k+7:8k] of the stored word. Word bit 0 (the first serial bit) appears on data bit 0.
- R6: Each registered trailing edge of the strobe moves the pointer up by one. Once the pointer reaches byte 3 it stays there, and further reads return byte 3 again.
- R7: A new word overwrites the stored word even if it is unread or half read. It returns the pointer to byte 0 and sets data-ready to 1.
- R8: The error flag takes the error status that arrives with each word. A word without an error clears the flag. The flag does not change between words or while the host reads.
- R9: When a word-valid pulse and a registered strobe edge fall in the same cycle, the word wins. The pointer goes to byte 0 and data-ready is 1.
- R10: The strobe passes through a two-stage synchroniser and an edge register. A trailing edge takes effect at the third clock edge after the strobe goes high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| word_vld | input | 1 | One-cycle pulse: a complete word is on word_in |
| word_in | input | 32 | Received word; bit 0 is the first serial bit |
| word_err | input | 1 | Bit-count error status of word_in, valid with word_vld |
| rd_n | input | 1 | Active-low host read strobe, asynchronous |
| host_data | output | 8 | Byte selected by the pointer |
| host_data_oe | output | 1 | Enable for the tri-state pad driver of host_data |
| data_rdy | output | 1 | High when an unread word waits in the buffer |
| word_error | output | 1 | Error status of the stored word |

## Verification
The bench attacks the overwrite cases. In one, a new word lands after two of the four bytes have been read; a design that keeps its pointer would return byte 2 of the new word instead of byte 0. In another, a word arrives in exactly the cycle a strobe edge is registered; letting the edge win would leave data-ready low or the pointer at byte 1. Reads past the fourth byte show whether the pointer wraps back to byte 0 instead of holding at byte 3. A flag that clears on the last read instead of the first would stay high through three extra read cycles, and the cycle-by-cycle model catches that along with any change in synchroniser latency.

// File: rtl/rxbp_pkg.sv
package rxbp_pkg;
    parameter int unsigned RXBP_BYTE_W    = 8;
    parameter int unsigned RXBP_NUM_BYTES = 4;
    parameter int unsigned RXBP_SYNC_STG  = 2;

    // Saturating increment of a byte pointer
    function automatic int unsigned ptr_step(input int unsigned cur, input int unsigned last);
        return (cur >= last) ? last : cur + 1;
    endfunction
endpackage

// File: rtl/rxbp_strobe_sync.sv
module rxbp_strobe_sync #(
    parameter int unsigned STAGES = rxbp_pkg::RXBP_SYNC_STG
) (
    input  logic clk,
    input  logic rst_n,
    input  logic strobe_n,
    output logic trail_edge
);
    logic [STAGES-1:0] sync_d, sync_q;
    logic              last_d, last_q;

    always_comb begin
        sync_d = {sync_q[STAGES-2:0], strobe_n};
        last_d = sync_q[STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= '1;
            last_q <= 1'b1;
        end else begin
            sync_q <= sync_d;
            last_q <= last_d;
        end
    end

    // Strobe released (low -> high) as seen after synchronisation
    assign trail_edge = sync_q[STAGES-1] & ~last_q;
endmodule

// File: rtl/rxbp_byte_mux.sv
module rxbp_byte_mux #(
    parameter int unsigned BYTE_W    = rxbp_pkg::RXBP_BYTE_W,
    parameter int unsigned NUM_BYTES = rxbp_pkg::RXBP_NUM_BYTES,
    localparam int unsigned WORD_W   = BYTE_W * NUM_BYTES,
    localparam int unsigned PTR_W    = (NUM_BYTES > 1) ? $clog2(NUM_BYTES) : 1
) (
    input  logic [WORD_W-1:0] word,
    input  logic [PTR_W-1:0]  sel,
    output logic [BYTE_W-1:0] lane
);
    logic [BYTE_W-1:0] lanes [NUM_BYTES];

    for (genvar g = 0; g < NUM_BYTES; g++) begin : g_lane
        assign lanes[g] = word[g*BYTE_W +: BYTE_W];
    end

    assign lane = lanes[sel];
endmodule

// File: rtl/rx_word_byte_port.sv
module rx_word_byte_port #(
    parameter int unsigned BYTE_W    = rxbp_pkg::RXBP_BYTE_W,
    parameter int unsigned NUM_BYTES = rxbp_pkg::RXBP_NUM_BYTES,
    parameter int unsigned SYNC_STG  = rxbp_pkg::RXBP_SYNC_STG,
    localparam int unsigned WORD_W   = BYTE_W * NUM_BYTES,
    localparam int unsigned PTR_W    = (NUM_BYTES > 1) ? $clog2(NUM_BYTES) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              word_vld,
    input  logic [WORD_W-1:0] word_in,
    input  logic              word_err,
    input  logic              rd_n,
    output logic [BYTE_W-1:0] host_data,
    output logic              host_data_oe,
    output logic              data_rdy,
    output logic              word_error
);
    localparam int unsigned LAST_IDX = NUM_BYTES - 1;

    typedef struct packed {
        logic [WORD_W-1:0] store;
        logic [PTR_W-1:0]  ptr;
        logic              rdy;
        logic              err;
    } port_state_t;

    port_state_t state_d, state_q;
    logic        rd_trail;
    logic [PTR_W-1:0] byte_ptr;

    rxbp_strobe_sync #(.STAGES(SYNC_STG)) u_sync (
        .clk        (clk),
        .rst_n      (rst_n),
        .strobe_n   (rd_n),
        .trail_edge (rd_trail)
    );

    always_comb begin
        state_d = state_q;
        if (word_vld) begin
            // New word wins over any read edge in the same cycle
            state_d.store = word_in;
            state_d.ptr   = '0;
            state_d.rdy   = 1'b1;
            state_d.err   = word_err;
        end else if (rd_trail) begin
            state_d.rdy = 1'b0;
            state_d.ptr = PTR_W'(rxbp_pkg::ptr_step(int'(state_q.ptr), LAST_IDX));
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    assign byte_ptr = state_q.ptr;

    rxbp_byte_mux #(.BYTE_W(BYTE_W), .NUM_BYTES(NUM_BYTES)) u_mux (
        .word (state_q.store),
        .sel  (byte_ptr),
        .lane (host_data)
    );

    assign host_data_oe = ~rd_n;
    assign data_rdy     = state_q.rdy;
    assign word_error   = state_q.err;
endmodule

// File: rtl/rx_word_byte_port_chk.sv
module rx_word_byte_port_chk #(
    parameter int unsigned PTR_W    = 2,
    parameter int unsigned LAST_IDX = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             word_vld,
    input logic             word_err,
    input logic             data_rdy,
    input logic             word_error,
    input logic [PTR_W-1:0] ptr
);
    p_rdy_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
        word_vld |=> data_rdy);

    p_rdy_no_self_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!word_vld && !data_rdy) |=> !data_rdy);

    p_ptr_hold_last_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!word_vld && ptr == PTR_W'(LAST_IDX)) |=> ptr == PTR_W'(LAST_IDX));

    p_ptr_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !word_vld |=> (ptr == $past(ptr) || ptr == $past(ptr) + 1'b1));

    p_ptr_restart_r7: assert property (@(posedge clk) disable iff (!rst_n)
        word_vld |=> ptr == '0);

    p_err_capture_r8: assert property (@(posedge clk) disable iff (!rst_n)
        word_vld |=> word_error == $past(word_err));

    p_err_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !word_vld |=> $stable(word_error));
endmodule

bind rx_word_byte_port rx_word_byte_port_chk #(
    .PTR_W    (PTR_W),
    .LAST_IDX (LAST_IDX)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .word_vld   (word_vld),
    .word_err   (word_err),
    .data_rdy   (data_rdy),
    .word_error (word_error),
    .ptr        (byte_ptr)
);

// File: tb/rx_word_byte_port_tb.sv
`timescale 1ns/1ps
module rx_word_byte_port_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        word_vld = 1'b0;
    logic [31:0] word_in = '0;
    logic        word_err = 1'b0;
    logic        rd_n = 1'b1;
    logic [7:0]  host_data;
    logic        host_data_oe;
    logic        data_rdy;
    logic        word_error;
    logic [7:0]  bus;

    int tests = 0;
    int fails = 0;

    always #5 clk = ~clk;

    rx_word_byte_port dut_i (
        .clk(clk), .rst_n(rst_n), .word_vld(word_vld), .word_in(word_in),
        .word_err(word_err), .rd_n(rd_n), .host_data(host_data),
        .host_data_oe(host_data_oe), .data_rdy(data_rdy), .word_error(word_error)
    );

    // Pad model: pulled-up bus driven only while the enable is high
    assign bus = host_data_oe ? host_data : 8'hFF;

    // ---------------- behavioural reference model ----------------
    logic [31:0] m_word;
    int          m_idx;
    bit          m_rdy, m_err;
    bit          rd_hist[$];

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_word = '0; m_idx = 0; m_rdy = 0; m_err = 0;
            rd_hist = '{1'b1, 1'b1, 1'b1};
        end else begin
            // R10: edge seen when the strobe sample 2 edges ago is high and 3 ago low
            bit edge_seen;
            edge_seen = rd_hist[1] && !rd_hist[2];
            if (word_vld) begin
                m_word = word_in; m_idx = 0; m_rdy = 1; m_err = word_err;
            end else if (edge_seen) begin
                m_rdy = 0;
                if (m_idx < 3) m_idx++;
            end
            rd_hist.push_front(rd_n);
            void'(rd_hist.pop_back());
        end
    end

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    // Cycle-by-cycle comparison 3 ns after each rising edge
    always @(posedge clk) begin
        #3;
        if (rst_n) begin
            chk("R2/R3/R7 data_rdy", {31'b0, data_rdy}, {31'b0, m_rdy});
            chk("R8 word_error", {31'b0, word_error}, {31'b0, m_err});
            chk("R4 oe", {31'b0, host_data_oe}, {31'b0, !rd_n});
            chk("R5/R6 bus", {24'b0, bus}, rd_n ? 32'hFF : {24'b0, m_word[8*m_idx +: 8]});
        end
    end

    // ---------------- stimulus ----------------
    task automatic send(logic [31:0] w, logic e);
        @(negedge clk); word_vld = 1; word_in = w; word_err = e;
        @(negedge clk); word_vld = 0; word_err = 0;
        @(posedge clk); #3;
    endtask

    task automatic rd_byte(output logic [7:0] b);
        @(negedge clk); rd_n = 0;
        @(negedge clk);
        @(posedge clk); #3; b = bus;
        @(negedge clk); rd_n = 1;
        repeat (5) @(negedge clk);
        @(posedge clk); #3;
    endtask

    bit done = 0;
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            fails++; tests++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        logic [7:0] b;
        repeat (3) @(negedge clk);
        @(posedge clk); #3;
        chk("R1 rdy in reset", {31'b0, data_rdy}, 0);
        chk("R1 err in reset", {31'b0, word_error}, 0);
        @(negedge clk); rst_n = 1;
        @(posedge clk); #3;
        chk("R1 rdy after reset", {31'b0, data_rdy}, 0);
        chk("R4 bus released idle", {31'b0, host_data_oe}, 0);
        rd_byte(b);
        chk("R1 empty buffer byte0", {24'b0, b}, 32'h00);

        // Full sequence, byte order and saturation
        send(32'hA1B2C3D4, 0);
        chk("R2 rdy after word", {31'b0, data_rdy}, 1);
        rd_byte(b); chk("R5 byte0", {24'b0, b}, 32'hD4);
        chk("R3 rdy cleared by first read", {31'b0, data_rdy}, 0);
        rd_byte(b); chk("R5 byte1", {24'b0, b}, 32'hC3);
        rd_byte(b); chk("R5 byte2", {24'b0, b}, 32'hB2);
        chk("R3 rdy stays low", {31'b0, data_rdy}, 0);
        rd_byte(b); chk("R5 byte3", {24'b0, b}, 32'hA1);
        rd_byte(b); chk("R6 saturate at byte3", {24'b0, b}, 32'hA1);
        rd_byte(b); chk("R6 saturate again", {24'b0, b}, 32'hA1);

        // Error word, overwrite mid-read
        send(32'h11223344, 1);
        chk("R8 err set", {31'b0, word_error}, 1);
        rd_byte(b); chk("R5 err word byte0", {24'b0, b}, 32'h44);
        chk("R8 err held across read", {31'b0, word_error}, 1);
        rd_byte(b); chk("R6 err word byte1", {24'b0, b}, 32'h33);
        send(32'h55667788, 0);
        chk("R8 err cleared by good word", {31'b0, word_error}, 0);
        chk("R7 rdy after overwrite", {31'b0, data_rdy}, 1);
        rd_byte(b); chk("R7 restart at byte0", {24'b0, b}, 32'h88);

        // Overwrite of an unread word
        send(32'hDEADBEEF, 0);
        send(32'hCAFEF00D, 0);
        rd_byte(b); chk("R7 unread word replaced", {24'b0, b}, 32'h0D);
        rd_byte(b); chk("R6 next byte", {24'b0, b}, 32'hF0);

        // Word and strobe edge in the same cycle
        @(negedge clk); rd_n = 0;
        repeat (2) @(negedge clk);
        rd_n = 1;                       // sampled at edge j
        @(negedge clk);                 // edge j+1
        @(negedge clk); word_vld = 1; word_in = 32'h0BADCAFE; word_err = 0; // edge j+2
        @(negedge clk); word_vld = 0;
        @(posedge clk); #3;
        chk("R9 word wins rdy", {31'b0, data_rdy}, 1);
        repeat (4) @(negedge clk);
        rd_byte(b); chk("R9 word wins ptr", {24'b0, b}, 32'hFE);
        rd_byte(b); chk("R10 pointer stepped once", {24'b0, b}, 32'hCA);

        // Reset mid-sequence
        send(32'h12345678, 1);
        @(negedge clk); rst_n = 0;
        @(posedge clk); #3;
        chk("R1 reset clears err", {31'b0, word_error}, 0);
        chk("R1 reset clears rdy", {31'b0, data_rdy}, 0);
        @(negedge clk); rst_n = 1;
        rd_byte(b); chk("R1 buffer cleared", {24'b0, b}, 32'h00);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule